// File: doc/BRIEF.md
# HyperBus Burst Read Controller

This block is the host side of a read-only HyperBus link to a HyperRAM-style memory. It takes a request made of a 3-bit command, a word address and a byte count, and runs one whole read transaction. First it holds chip select inactive for one cycle with the data bus driven to zero. Then it sends a 48-bit command-address word as six bytes. It counts out the access latency, releases the data bus, captures one read byte on every bus clock edge, and delivers each byte on a byte-wide stream with a valid strobe.

The model runs at one bus clock edge per system clock cycle. The bus clock output toggles once in every cycle while chip select is low, so one system cycle carries one DDR byte. The initial latency L sits in a small register that software may rewrite. The latency is doubled when the device runs with fixed latency (configuration input), or when it raises RWDS during the command-address phase. A busy/done handshake covers one transaction at a time. Bursts run from 1 to 65536 bytes.

Top module: `hbus_rd_ctrl`

## Requirements
- R1: After reset, hb_cs_n is 1, hb_ck is 0, hb_dq_oe is 0, busy is 0 and rd_valid is 0.
- R2: The command-address phase takes six consecutive cycles with hb_cs_n low and hb_dq_oe high. Each cycle presents one byte of a 48-bit word, most significant byte first. Bits 47:45 of the word hold req_cmd. Bits 44:0 hold req_addr zero-extended, with its low three bits forced to 0.
- R3: In the cycle just before hb_cs_n falls, hb_cs_n is 1, hb_dq_oe is 1 and hb_dq_out is 8'h00.
- R4: The latency register resets to 6. A cfg_lat_we pulse with cfg_lat in the range 3 to 7 loads it. Any other value leaves it unchanged. Each request uses the value held when it is accepted.
- R5: The latency window after the first four command-address bytes lasts 2+Lc edges, where Lc is L when single and 2L when doubled. It includes the two final command-address bytes. Latency is doubled when cfg_fixed is 1, or when hb_rwds is high during the third command-address cycle. Data byte k is sampled from hb_dq_in in the cycle 6+Lc+k counted from the first chip-select-low cycle.
- R6: hb_dq_oe is 0 from the cycle after the last command-address byte until chip select rises.
- R7: Every one of the N requested bytes appears on rd_data in order, with rd_valid high, in the cycle after it was sampled. No other cycle has rd_valid high.
- R8: hb_ck toggles in every chip-select-low cycle and is 0 whenever hb_cs_n is 1. The number of chip-select-low cycles is 6+Lc+N, plus one more when that sum is odd.
- R9: hb_cs_n returns to 1 in the cycle after the last clock edge, and done pulses in that same cycle. busy is high from the cycle after acceptance through the done cycle. A request made while busy is high is ignored.
- R10: A request with req_len equal to 0 is ignored. A length of 65536 completes in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bus clock edge per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_cmd | input | 3 | Command placed in the top bits of the command-address word |
| req_addr | input | 32 | Word address, aligned down to 16 bytes when sent |
| req_len | input | 17 | Byte count, 1 to 65536 |
| cfg_lat_we | input | 1 | Latency register write strobe |
| cfg_lat | input | 3 | New latency value, accepted if 3 to 7 |
| cfg_fixed | input | 1 | 1 = device uses fixed (always doubled) latency |
| hb_rwds | input | 1 | RWDS level from the device |
| hb_dq_in | input | 8 | Data bus input |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the transaction ends |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_ck | output | 1 | Bus clock |
| hb_dq_out | output | 8 | Data bus output value |
| hb_dq_oe | output | 1 | Data bus output enable |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | rd_data holds a new byte |

## Verification
Transactions cover single latency, fixed doubling and RWDS doubling. These separate the L and 2L window paths, and so the sampling cycle of the first data byte. Latencies of 3, 6 and 7 pair with lengths that give both odd and even edge totals, which exercises the extra tail edge and the low-stopping clock. Outside its data window the device model drives a marker byte, so any shift in the capture point shows up as wrong data. An unaligned address shows the alignment. An out-of-range latency write, a zero-length request and a request made while busy each have to leave the bus unchanged. A 65536-byte burst covers the full-length case.

// File: rtl/hbus_rd_pkg.sv
// Shared types and helpers for the HyperBus read controller.
// Assumes a 48-bit command-address word with a 3-bit command on top.
package hbus_rd_pkg;

    localparam int CA_W   = 48;
    localparam int CMD_W  = 3;
    localparam int CAA_W  = CA_W - CMD_W;
    localparam int CA_BYTES = CA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CA,
        ST_LAT,
        ST_DATA,
        ST_TAIL,
        ST_DONE
    } hb_state_t;

    // Builds the command-address word with the address aligned to 16 bytes.
    function automatic logic [CA_W-1:0] ca_pack(input logic [CMD_W-1:0] cmd,
                                                input logic [CAA_W-1:0] addr);
        return {cmd, addr & ~CAA_W'(7)};
    endfunction

endpackage

// File: rtl/hbus_lat_reg.sv
// Initial-latency setting register.
// Loads a new value only when it lies inside [LAT_MIN, LAT_MAX]; resets to LAT_RST.
module hbus_lat_reg #(
    parameter int LAT_W   = 3,
    parameter int LAT_MIN = 3,
    parameter int LAT_MAX = 7,
    parameter int LAT_RST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LAT_W-1:0] wdata,
    output logic [LAT_W-1:0] lat
);

    logic in_range;

    // Range test on the write value.
    always_comb in_range = (int'(wdata) >= LAT_MIN) && (int'(wdata) <= LAT_MAX);

    // Holds the latency setting.
    always_ff @(posedge clk) begin
        if (!rst_n)              lat <= LAT_W'(LAT_RST);
        else if (we && in_range) lat <= wdata;
    end

    // R4
    always @(posedge clk) begin
        if (rst_n) lat_range_chk : assert (int'(lat) >= LAT_MIN && int'(lat) <= LAT_MAX);
    end

endmodule

// File: rtl/hbus_rd_capture.sv
// Read data capture: registers the bus byte on each enabled edge-step.
// Assumes the sequencer raises cap_en exactly in the cycles whose data is valid.
module hbus_rd_capture #(
    parameter int DQ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] rd_data,
    output logic            rd_valid
);

    // Samples the bus and flags the byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/hbus_rd_seq.sv
// Transaction sequencer: pre-drive, command-address, latency, data and tail phases.
// Assumes one bus clock edge per system cycle and a request length of at least one.
module hbus_rd_seq
    import hbus_rd_pkg::*;
#(
    parameter int LEN_W = 17,
    parameter int LAT_W = 3,
    parameter int DQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CA_W-1:0]  req_ca,
    input  logic [LEN_W-1:0] req_len,
    input  logic [LAT_W-1:0] lat_set,
    input  logic             fixed_lat,
    input  logic             rwds_in,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             ck,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe,
    output logic             cap_en
);

    localparam int CA_LAST  = CA_BYTES - 1;
    localparam int RWDS_AT  = CA_BYTES - 3;

    hb_state_t        state_q;
    logic [CA_W-1:0]  ca_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [LAT_W-1:0] lat_q;
    logic             dbl_q;
    logic             ck_q;
    logic [LAT_W:0]   lat_cycles;
    logic             accept;
    logic             active;

    // Latency cycles after the last command-address byte.
    always_comb lat_cycles = dbl_q ? {lat_q, 1'b0} : {1'b0, lat_q};

    // Request acceptance and clocked-phase decode.
    always_comb begin
        accept = (state_q == ST_IDLE) && req_valid && (req_len != '0);
        active = (state_q == ST_CA) || (state_q == ST_LAT) ||
                 (state_q == ST_DATA) || (state_q == ST_TAIL);
    end

    // Phase state machine with its step counter and latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ca_q    <= '0;
            cnt_q   <= '0;
            len_q   <= '0;
            lat_q   <= '0;
            dbl_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    ca_q    <= req_ca;
                    len_q   <= req_len;
                    lat_q   <= lat_set;
                    dbl_q   <= 1'b0;
                    state_q <= ST_PRE;
                end
                ST_PRE: begin
                    cnt_q   <= LEN_W'(CA_LAST);
                    state_q <= ST_CA;
                end
                ST_CA: begin
                    ca_q <= ca_q << 8;
                    if (cnt_q == LEN_W'(RWDS_AT)) dbl_q <= fixed_lat | rwds_in;
                    if (cnt_q == '0) begin
                        cnt_q   <= LEN_W'(lat_cycles) - 1'b1;
                        state_q <= ST_LAT;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_LAT: begin
                    if (cnt_q == '0) begin
                        cnt_q   <= len_q - 1'b1;
                        state_q <= ST_DATA;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt_q == '0)
                        state_q <= (lat_cycles[0] ^ len_q[0]) ? ST_TAIL : ST_DONE;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                ST_TAIL: state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus clock: one toggle per active cycle, parked low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) ck_q <= 1'b0;
        else        ck_q <= active ? ~ck_q : 1'b0;
    end

    // Pin and handshake decode per phase.
    always_comb begin
        cs_n   = 1'b1;
        dq_oe  = 1'b0;
        dq_out = '0;
        cap_en = 1'b0;
        done   = 1'b0;
        busy   = (state_q != ST_IDLE);
        ck     = ck_q;
        case (state_q)
            ST_PRE:  dq_oe = 1'b1;
            ST_CA: begin
                cs_n   = 1'b0;
                dq_oe  = 1'b1;
                dq_out = ca_q[CA_W-1 -: DQ_W];
            end
            ST_LAT:  cs_n = 1'b0;
            ST_DATA: begin
                cs_n   = 1'b0;
                cap_en = 1'b1;
            end
            ST_TAIL: cs_n = 1'b0;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R3
    pre_drive_chk : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(dq_oe) && $past(dq_out) == '0));

    // R6
    bus_released_chk : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_en) |-> !$past(dq_oe));

    // R8
    ck_parked_chk : assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !ck);

    // R9
    done_cs_chk : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    // R10
    zero_len_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_len == '0) |=> state_q == ST_IDLE);

endmodule

// File: rtl/hbus_rd_ctrl.sv
// Top of the HyperBus read controller: latency register, sequencer, capture.
// Assumes ADDR_W fits below the command field and LEN_W covers the largest burst.
module hbus_rd_ctrl
    import hbus_rd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17,
    parameter int LAT_W  = 3,
    parameter int DQ_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              cfg_lat_we,
    input  logic [LAT_W-1:0]  cfg_lat,
    input  logic              cfg_fixed,
    input  logic              hb_rwds,
    input  logic [DQ_W-1:0]   hb_dq_in,
    output logic              busy,
    output logic              done,
    output logic              hb_cs_n,
    output logic              hb_ck,
    output logic [DQ_W-1:0]   hb_dq_out,
    output logic              hb_dq_oe,
    output logic [DQ_W-1:0]   rd_data,
    output logic              rd_valid
);

    logic [LAT_W-1:0] lat_now;
    logic [CA_W-1:0]  ca_word;
    logic             cap_en;

    // Command-address word from the request fields.
    always_comb ca_word = ca_pack(req_cmd, CAA_W'(req_addr));

    hbus_lat_reg #(.LAT_W(LAT_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_lat_we),
        .wdata (cfg_lat),
        .lat   (lat_now)
    );

    hbus_rd_seq #(.LEN_W(LEN_W), .LAT_W(LAT_W), .DQ_W(DQ_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ca    (ca_word),
        .req_len   (req_len),
        .lat_set   (lat_now),
        .fixed_lat (cfg_fixed),
        .rwds_in   (hb_rwds),
        .busy      (busy),
        .done      (done),
        .cs_n      (hb_cs_n),
        .ck        (hb_ck),
        .dq_out    (hb_dq_out),
        .dq_oe     (hb_dq_oe),
        .cap_en    (cap_en)
    );

    hbus_rd_capture #(.DQ_W(DQ_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .dq_in    (hb_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R7
    valid_in_txn_chk : assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!hb_cs_n || done));

    // R9
    busy_idle_cs_chk : assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> hb_cs_n);

endmodule

// File: tb/tb_hbus_rd_ctrl.sv
`timescale 1ns/1ps
module tb_hbus_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [16:0] req_len = '0;
    logic        cfg_lat_we = 1'b0;
    logic [2:0]  cfg_lat = '0;
    logic        cfg_fixed = 1'b0;
    logic        hb_rwds = 1'b0;
    logic [7:0]  hb_dq_in = 8'hEE;
    logic        busy, done, hb_cs_n, hb_ck, hb_dq_oe, rd_valid;
    logic [7:0]  hb_dq_out, rd_data;

    hbus_rd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .cfg_lat_we(cfg_lat_we),
        .cfg_lat(cfg_lat), .cfg_fixed(cfg_fixed), .hb_rwds(hb_rwds),
        .hb_dq_in(hb_dq_in), .busy(busy), .done(done), .hb_cs_n(hb_cs_n),
        .hb_ck(hb_ck), .hb_dq_out(hb_dq_out), .hb_dq_oe(hb_dq_oe),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #2 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int tm_lat = 6;
    int exp_lc = 0;
    int exp_len = 0;
    int dev_cnt = 0;
    int last_low = 0;
    int cs_falls = 0;
    int seed = 0;
    logic [47:0] ca_cap = '0;
    logic [7:0]  exp_q[$];
    bit oe_bad = 0;
    bit pre_bad = 0;
    bit ck_bad = 0;
    bit prev_oe = 0;
    logic [7:0] prev_dq = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + seed) & 255);
    endfunction

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Device model and scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!hb_cs_n) begin
                if (dev_cnt == 0) begin
                    cs_falls++;
                    if (!(prev_oe && prev_dq == 8'h00)) pre_bad = 1;
                end
                if (dev_cnt < 6) begin
                    ca_cap = {ca_cap[39:0], hb_dq_out};
                    if (!hb_dq_oe) oe_bad = 1;
                end else if (hb_dq_oe) oe_bad = 1;
                if (dev_cnt >= 6 + exp_lc && dev_cnt < 6 + exp_lc + exp_len)
                    hb_dq_in = pat(dev_cnt - 6 - exp_lc);
                else
                    hb_dq_in = 8'hEE;
                dev_cnt++;
            end else begin
                if (dev_cnt != 0) last_low = dev_cnt;
                dev_cnt = 0;
                hb_dq_in = 8'hEE;
            end
            if (hb_cs_n && hb_ck) ck_bad = 1;
            if (rd_valid) begin
                if (exp_q.size() == 0) chk(0, "R7 unexpected byte", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R7 read byte", rd_data, e);
                end
            end
            prev_oe = hb_dq_oe;
            prev_dq = hb_dq_out;
        end
    end

    task automatic set_lat(input int v);
        @(negedge clk);
        cfg_lat_we = 1'b1;
        cfg_lat = 3'(v);
        @(negedge clk);
        cfg_lat_we = 1'b0;
        if (v >= 3 && v <= 7) tm_lat = v;
    endtask

    task automatic run(input logic [2:0] cmd, input logic [31:0] addr, input int len,
                       input bit rwds, input bit extra_req);
        int falls0;
        int exp_low;
        logic [47:0] exp_ca;
        exp_lc  = (cfg_fixed || rwds) ? 2 * tm_lat : tm_lat;
        exp_len = len;
        seed    = seed + 11;
        oe_bad  = 0;
        pre_bad = 0;
        for (int k = 0; k < len; k++) exp_q.push_back(pat(k));
        falls0 = cs_falls;
        @(negedge clk);
        hb_rwds   = rwds;
        req_cmd   = cmd;
        req_addr  = addr;
        req_len   = 17'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (extra_req) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R9 busy during transaction", busy, 1);
            req_cmd = 3'd5;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        do @(negedge clk); while (!done);
        chk(hb_cs_n == 1'b1, "R9 cs high at done", hb_cs_n, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy clears after done", busy, 0);
        repeat (3) @(negedge clk);
        exp_ca  = {cmd, 13'b0, addr[31:3], 3'b000};
        exp_low = 6 + exp_lc + len;
        if (exp_low % 2 == 1) exp_low++;
        chk(ca_cap == exp_ca, "R2 command-address word", ca_cap, exp_ca);
        chk(pre_bad == 0, "R3 zero pre-drive", pre_bad, 0);
        chk(oe_bad == 0, "R6 bus release", oe_bad, 0);
        chk(last_low == exp_low, "R5 R8 cs-low cycle count", last_low, exp_low);
        chk(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
        chk(cs_falls == falls0 + 1, "R9 one transaction", cs_falls - falls0, 1);
        chk(ck_bad == 0, "R8 clock parked low", ck_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(hb_cs_n == 1'b1, "R1 cs_n", hb_cs_n, 1);
        chk(hb_ck == 1'b0, "R1 ck", hb_ck, 0);
        chk(hb_dq_oe == 1'b0, "R1 oe", hb_dq_oe, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 default 6 with fixed doubling (R5)
        cfg_fixed = 1'b1;
        run(3'b101, 32'h0000_0010, 4, 0, 0);
        // R5 single latency, odd total adds tail edge (R8)
        cfg_fixed = 1'b0;
        run(3'b100, 32'h0000_0040, 5, 0, 0);
        // R5 doubled by RWDS high
        run(3'b110, 32'h0001_0000, 6, 1, 0);
        // R4 latency 3, fixed
        set_lat(3);
        cfg_fixed = 1'b1;
        run(3'b101, 32'h0000_0020, 1, 0, 0);
        // R4 latency 7, variable, single
        set_lat(7);
        cfg_fixed = 1'b0;
        run(3'b100, 32'h0000_0100, 8, 0, 0);
        // R4 out-of-range write ignored: latency stays 7
        set_lat(2);
        run(3'b100, 32'h0000_0200, 3, 0, 0);
        set_lat(0);
        run(3'b100, 32'h0000_0300, 2, 1, 0);
        // R2 address alignment
        set_lat(6);
        run(3'b111, 32'h1234_567F, 9, 0, 0);
        // R9 request while busy ignored
        run(3'b100, 32'h0000_0400, 20, 0, 1);
        // R10 zero length ignored
        begin
            int f0;
            f0 = cs_falls;
            @(negedge clk);
            req_len = '0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (20) @(negedge clk);
            chk(cs_falls == f0, "R10 zero length ignored", cs_falls - f0, 0);
            chk(busy == 1'b0, "R10 busy stays low", busy, 0);
        end
        // R10 full 64 KiB burst
        cfg_fixed = 1'b1;
        run(3'b101, 32'h0000_8000, 65536, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule